// File: doc/BRIEF.md
# Card-Bus Access Sizing Sequencer

This block sits between a host load/store port and a card bus that carries 8- and 16-bit targets. Each accepted request names an access size, the two low address bits, a space type and, for stores, 32 bits of write data. The block settles the target's bus width for that request, then runs one or two card-bus transfers. In each transfer it drives the two active-low card-enable strobes, places the data on the right byte lane and, for loads, picks up the returned bytes. A half-word aimed at an 8-bit target is broken into two byte transfers on the lower lane, even byte first. Every combination of size, width and alignment with no defined bus behaviour is refused: no bus cycle is run and the response carries an error flag.

Requests arrive on a valid/ready port and results leave on a second valid/ready port. The request port is ready only while no request is in flight. A response is held, with its data and error flag unchanged, until the consumer takes it, and no new request is accepted before that. Each card-bus transfer lasts exactly one clock cycle. The 16-bit indicator from the target is a plain input. It is sampled in the cycle the request is accepted.

Top module: `cardbus_sizer`

## Requirements
- R1: Space code 0 (memory) and code 1 (attribute) are always 16-bit. Space code 2 (I/O) is 16-bit when `io16_n` is low in the accept cycle, and 8-bit when it is high.
- R2: A word access (size code 2) to a 16-bit target at address 00 is one transfer. Both strobes are low, `bus_addr` is 00, the store data `req_wdata` is passed whole to `bus_wdata`, and a load returns all 32 bus bits.
- R3: A half-word access (size code 1) to a 16-bit target at an even address is one transfer. Both strobes are low, stores drive `req_wdata[15:0]` on bits [15:0], and a load returns bus bits [15:0] zero-extended.
- R4: A half-word access to an 8-bit target at an even address is two consecutive transfers. In both, `ce_lo_n` is low and `ce_hi_n` is high. `bus_addr` is the request address in the first and has bit 0 set to 1 in the second. A store drives `req_wdata[7:0]` and then `req_wdata[15:8]` on bits [7:0]. A load returns the first byte in [7:0] and the second in [15:8], and gives one response in the cycle after the second transfer.
- R5: A byte access (size code 0) to a 16-bit target with address bit 0 = 0 uses the lower lane with only `ce_lo_n` low. With address bit 0 = 1 it uses the upper lane with only `ce_hi_n` low. On the upper lane, a store drives the write byte on both [15:8] and [7:0], and a load returns bus bits [15:8] in `rsp_rdata[7:0]`.
- R6: A byte access to an 8-bit target uses the lower lane with only `ce_lo_n` low at any address. A load returns bus bits [7:0].
- R7: The following requests run no transfer, and their response has `rsp_err` = 1 and `rsp_rdata` = 0: a word to an 8-bit target, a word at a nonzero address, a half-word at an odd address, size code 3, and space code 3. Both strobes stay high from acceptance to response.
- R8: `req_ready` is high only when no request is in flight. A request is taken on `req_valid && req_ready`. A single-transfer request gives `rsp_valid` two cycles after acceptance, and an error one cycle after. `rsp_valid`, `rsp_err` and `rsp_rdata` hold steady until `rsp_ready`. A request offered while busy is not taken.
- R9: Outside a transfer, both strobes are high, `bus_we` is 0 and `bus_wdata` is 0. `bus_wdata` is 0 during loads, and `rsp_rdata` is 0 for stores.
- R10: While `rst_n` is low, `req_ready` is 1, `rsp_valid` is 0 and both strobes are high. Any request in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_addr | input | 2 | Low two address bits |
| req_space | input | 2 | 0 memory, 1 attribute, 2 I/O, 3 reserved |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data, right-aligned |
| io16_n | input | 1 | Target 16-bit indicator, active low |
| ce_lo_n | output | 1 | Lower-lane card enable, active low |
| ce_hi_n | output | 1 | Upper-lane card enable, active low |
| bus_addr | output | 2 | Low address bits of the current transfer |
| bus_we | output | 1 | Current transfer is a store |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_rdata | input | 32 | Card-bus read data, sampled at the end of each transfer cycle |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Request was refused as undefined |
| rsp_rdata | output | 32 | Assembled load data |

## Verification
The bench counts cycles from acceptance and checks the strobes, the transfer address and the store data in each transfer cycle. The register that holds the access plan is loaded at acceptance. A wrong plan therefore shows up in the very next cycle as a wrong strobe pair or a wrong lane. A fault in the sequencer shows up as a missing or extra second transfer, or as `rsp_valid` rising a cycle early or late. A fault in the read accumulator shows up only at the response, as a byte in the wrong half or a stale byte left over from an earlier load. For that reason the split-load vectors return different data for the even and odd addresses.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int DW     = 32;
  localparam int LANE_W = 8;
  localparam int HALF_W = 2 * LANE_W;
  localparam int AW     = 2;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} size_e;
  typedef enum logic [1:0] {SP_MEM = 2'd0, SP_ATTR = 2'd1, SP_IO = 2'd2, SP_RSVD = 2'd3} space_e;
  typedef enum logic [1:0] {K_BYTE_LO, K_BYTE_HI, K_HALF, K_WORD} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_X1, S_X2, S_RSP} state_e;

  // ce_n is {hi, lo}
  typedef struct packed {
    logic       err;
    logic       split;
    logic [1:0] ce_n;
    kind_e      kind;
  } plan_t;
endpackage

// File: rtl/cbs_decode.sv
module cbs_decode
  import cbs_pkg::*;
(
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    space,
  input  logic          io16_n,
  output plan_t         plan
);
  logic wide;

  always_comb begin
    wide = (space == SP_MEM) || (space == SP_ATTR) || ((space == SP_IO) && !io16_n);
    plan = '{err: 1'b1, split: 1'b0, ce_n: 2'b11, kind: K_BYTE_LO};
    if (space != SP_RSVD) begin
      case (size)
        SZ_WORD: begin
          if (wide && addr == '0)
            plan = '{err: 1'b0, split: 1'b0, ce_n: 2'b00, kind: K_WORD};
        end
        SZ_HALF: begin
          if (!addr[0]) begin
            if (wide) plan = '{err: 1'b0, split: 1'b0, ce_n: 2'b00, kind: K_HALF};
            else      plan = '{err: 1'b0, split: 1'b1, ce_n: 2'b10, kind: K_BYTE_LO};
          end
        end
        SZ_BYTE: begin
          if (wide && addr[0]) plan = '{err: 1'b0, split: 1'b0, ce_n: 2'b01, kind: K_BYTE_HI};
          else                 plan = '{err: 1'b0, split: 1'b0, ce_n: 2'b10, kind: K_BYTE_LO};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbs_lanes.sv
module cbs_lanes
  import cbs_pkg::*;
(
  input  kind_e         kind,
  input  logic          second,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] lane_wdata,
  output logic [DW-1:0] rd_slice
);
  localparam int UPPER_PAD = DW - HALF_W;
  localparam int BYTE_PAD  = DW - LANE_W;

  always_comb begin
    case (kind)
      K_BYTE_LO: lane_wdata = {{BYTE_PAD{1'b0}},
                               second ? wdata[HALF_W-1:LANE_W] : wdata[LANE_W-1:0]};
      K_BYTE_HI: lane_wdata = {{UPPER_PAD{1'b0}}, wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
      K_HALF:    lane_wdata = {{UPPER_PAD{1'b0}}, wdata[HALF_W-1:0]};
      default:   lane_wdata = wdata;
    endcase
  end

  always_comb begin
    case (kind)
      K_BYTE_LO: rd_slice = second
                   ? {{UPPER_PAD{1'b0}}, bus_rdata[LANE_W-1:0], {LANE_W{1'b0}}}
                   : {{BYTE_PAD{1'b0}}, bus_rdata[LANE_W-1:0]};
      K_BYTE_HI: rd_slice = {{BYTE_PAD{1'b0}}, bus_rdata[HALF_W-1:LANE_W]};
      K_HALF:    rd_slice = {{UPPER_PAD{1'b0}}, bus_rdata[HALF_W-1:0]};
      default:   rd_slice = bus_rdata;
    endcase
  end
endmodule

// File: rtl/cardbus_sizer.sv
module cardbus_sizer
  import cbs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_size,
  input  logic [1:0]    req_addr,
  input  logic [1:0]    req_space,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  input  logic          io16_n,
  output logic          ce_lo_n,
  output logic          ce_hi_n,
  output logic [1:0]    bus_addr,
  output logic          bus_we,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata
);
  state_e        state_q, state_d;
  plan_t         plan_in, plan_q;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wd_q, acc_q, lane_wdata, rd_slice;
  logic          accept, xfer, second;
  logic [1:0]    ce_n;

  cbs_decode u_decode (
    .size   (req_size),
    .addr   (req_addr),
    .space  (req_space),
    .io16_n (io16_n),
    .plan   (plan_in)
  );

  cbs_lanes u_lanes (
    .kind       (plan_q.kind),
    .second     (second),
    .wdata      (wd_q),
    .bus_rdata  (bus_rdata),
    .lane_wdata (lane_wdata),
    .rd_slice   (rd_slice)
  );

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign xfer      = (state_q == S_X1) || (state_q == S_X2);
  assign second    = (state_q == S_X2);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (accept) state_d = plan_in.err ? S_RSP : S_X1;
      S_X1:   state_d = plan_q.split ? S_X2 : S_RSP;
      S_X2:   state_d = S_RSP;
      S_RSP:  if (rsp_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      plan_q  <= '{err: 1'b0, split: 1'b0, ce_n: 2'b11, kind: K_BYTE_LO};
      addr_q  <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        plan_q <= plan_in;
        addr_q <= req_addr;
        we_q   <= req_write;
        wd_q   <= req_wdata;
        acc_q  <= '0;
      end else if (xfer && !we_q) begin
        acc_q <= acc_q | rd_slice;
      end
    end
  end

  always_comb begin
    case (state_q)
      S_X1:    ce_n = plan_q.ce_n;
      S_X2:    ce_n = 2'b10;
      default: ce_n = 2'b11;
    endcase
  end
  assign {ce_hi_n, ce_lo_n} = ce_n;

  assign bus_addr  = (state_q == S_X1) ? addr_q :
                     (state_q == S_X2) ? {addr_q[1], 1'b1} : '0;
  assign bus_we    = xfer && we_q;
  assign bus_wdata = bus_we ? lane_wdata : '0;

  assign rsp_valid = (state_q == S_RSP);
  assign rsp_err   = rsp_valid && plan_q.err;
  assign rsp_rdata = rsp_valid ? acc_q : '0;

  // response stays put under back-pressure
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // a refused request never ran a bus cycle
  assert_err_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> $past(ce_lo_n) && $past(ce_hi_n));

  assert_word_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && plan_q.kind == K_WORD |-> !ce_lo_n && !ce_hi_n);

  assert_byte_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && (plan_q.kind == K_BYTE_LO || plan_q.kind == K_BYTE_HI)
    |-> $countones({ce_hi_n, ce_lo_n}) == 1);

  assert_split_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    second |-> !ce_lo_n && ce_hi_n && bus_addr[0] && $past(state_q == S_X1));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |-> ce_lo_n && ce_hi_n && !bus_we && bus_wdata == '0);
endmodule

// File: tb/cardbus_sizer_bench.sv
module cardbus_sizer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, io16_n = 1'b1, rsp_ready = 1'b1;
  logic [1:0]  req_size = '0, req_addr = '0, req_space = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, ce_lo_n, ce_hi_n, bus_we, rsp_valid, rsp_err;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rsp_rdata;

  localparam logic [31:0] RD_EVEN = 32'h11223344;
  localparam logic [31:0] RD_ODD  = 32'h55667788;
  localparam logic [31:0] WDATA   = 32'hA1B2C3D4;

  always #10 clk = ~clk;
  assign bus_rdata = bus_addr[0] ? RD_ODD : RD_EVEN;

  cardbus_sizer u_cardbus_sizer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_addr(req_addr), .req_space(req_space),
    .req_write(req_write), .req_wdata(req_wdata), .io16_n(io16_n),
    .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic [1:0]  ad;
    logic [1:0]  sp;
    logic        io16n;
    logic        we;
    logic        err;
    logic [1:0]  n;
    logic [1:0]  s1;   // {ce_hi_n, ce_lo_n} in first transfer
    logic [31:0] wd1;
    logic [31:0] wd2;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 2'b00, 32'h0,        32'h0,  32'h11223344},
    '{2'd2, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 2'd1, 2'b00, 32'hA1B2C3D4, 32'h0,  32'h0},
    '{2'd2, 2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 2'd0, 2'b11, 32'h0,        32'h0,  32'h0},
    '{2'd2, 2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 2'b11, 32'h0,        32'h0,  32'h0},
    '{2'd2, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 2'd0, 2'b11, 32'h0,        32'h0,  32'h0},
    '{2'd1, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 2'b00, 32'h0,        32'h0,  32'h3344},
    '{2'd1, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1, 2'b00, 32'hC3D4,     32'h0,  32'h0},
    '{2'd1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 2'b11, 32'h0,        32'h0,  32'h0},
    '{2'd1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 2'b10, 32'h0,        32'h0,  32'h8844},
    '{2'd1, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 2'd2, 2'b10, 32'hD4,       32'hC3, 32'h0},
    '{2'd1, 2'd3, 2'd2, 1'b1, 1'b0, 1'b1, 2'd0, 2'b11, 32'h0,        32'h0,  32'h0},
    '{2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 2'b10, 32'h0,        32'h0,  32'h44},
    '{2'd0, 2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b01, 32'hD4D4,     32'h0,  32'h0},
    '{2'd0, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 2'b01, 32'h0,        32'h0,  32'h77},
    '{2'd0, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 2'd1, 2'b10, 32'h0,        32'h0,  32'h88},
    '{2'd0, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 2'd1, 2'b10, 32'hD4,       32'h0,  32'h0},
    '{2'd1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 32'h0,        32'h0,  32'h3344},
    '{2'd3, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 2'b11, 32'h0,        32'h0,  32'h0},
    '{2'd0, 2'd0, 2'd3, 1'b1, 1'b0, 1'b1, 2'd0, 2'b11, 32'h0,        32'h0,  32'h0},
    '{2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 2'b01, 32'h0,        32'h0,  32'h77}
  };

  int total = 0;
  int fails = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    string t;
    if (v.err)            t = "R7";
    else if (v.n == 2'd2) t = "R4";
    else if (v.sz == 2'd2) t = "R2";
    else if (v.sz == 2'd1) t = "R3";
    else if (v.sp != 2'd2 || !v.io16n) t = "R5";
    else                  t = "R6";
    if (v.sp == 2'd2) t = {t, " R1"};
    return t;
  endfunction

  task automatic issue(input logic [1:0] sz, input logic [1:0] ad, input logic [1:0] sp,
                       input logic io, input logic we);
    @(negedge clk);
    req_size = sz; req_addr = ad; req_space = sp; io16_n = io;
    req_write = we; req_wdata = WDATA; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_table();
    for (int i = 0; i < NV; i++) begin
      vec_t  v;
      string tg;
      v  = TBL[i];
      tg = $sformatf("%s vec%0d", tag_of(v), i);
      rsp_ready = 1'b1;
      issue(v.sz, v.ad, v.sp, v.io16n, v.we);
      for (int t = 0; t < 2; t++) begin
        if (t < int'(v.n)) begin
          if (t > 0) @(negedge clk);
          check({tg, " strobes"}, 32'({ce_hi_n, ce_lo_n}), 32'(t == 0 ? v.s1 : 2'b10));
          check({tg, " bus_addr"}, 32'(bus_addr), 32'(t == 0 ? v.ad : {v.ad[1], 1'b1}));
          check({tg, " bus_we"}, 32'(bus_we), 32'(v.we));
          check({tg, " bus_wdata"}, bus_wdata, t == 0 ? v.wd1 : v.wd2);
        end
      end
      if (v.n != 2'd0) @(negedge clk);
      // R8 response timing, R9 quiet bus during response
      check({tg, " R8 rsp_valid"}, 32'(rsp_valid), 32'd1);
      check({tg, " rsp_err"}, 32'(rsp_err), 32'(v.err));
      check({tg, " rsp_rdata"}, rsp_rdata, v.rd);
      check({tg, " R9 strobes idle"}, 32'({ce_hi_n, ce_lo_n}), 32'd3);
      @(negedge clk);
      check({tg, " R8 single-cycle rsp"}, 32'(rsp_valid), 32'd0);
      check({tg, " R8 ready again"}, 32'(req_ready), 32'd1);
    end
  endtask

  task automatic run_directed();
    // R8 back-pressure and busy request ignored
    rsp_ready = 1'b0;
    issue(2'd1, 2'd0, 2'd0, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 bp rsp_valid", 32'(rsp_valid), 32'd1);
    check("R3 bp rdata", rsp_rdata, 32'h3344);
    req_size = 2'd0; req_addr = 2'd1; req_space = 2'd0; req_write = 1'b1; req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 bp hold valid", 32'(rsp_valid), 32'd1);
      check("R8 bp hold data", rsp_rdata, 32'h3344);
      check("R8 bp not ready", 32'(req_ready), 32'd0);
      check("R9 bp strobes high", 32'({ce_hi_n, ce_lo_n}), 32'd3);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 bp released", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    check("R8 busy request dropped", 32'({ce_hi_n, ce_lo_n}), 32'd3);
    check("R9 no write after drop", bus_wdata, 32'h0);

    // R10 reset in the middle of a split load
    issue(2'd1, 2'd0, 2'd2, 1'b1, 1'b0);
    check("R4 split first strobe", 32'({ce_hi_n, ce_lo_n}), 32'd2);
    rst_n = 1'b0;
    #1;
    check("R10 strobes on reset", 32'({ce_hi_n, ce_lo_n}), 32'd3);
    check("R10 ready on reset", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 no resumed xfer", 32'({ce_hi_n, ce_lo_n}), 32'd3);
    check("R10 no response", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (2) @(negedge clk);
        check("R10 reset ready", 32'(req_ready), 32'd1);
        check("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R10 reset strobes", 32'({ce_hi_n, ce_lo_n}), 32'd3);
        check("R9 reset wdata", bus_wdata, 32'h0);
        rst_n = 1'b1;
        run_table();
        run_directed();
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule